// File: doc/BRIEF.md
# Video-to-Stream Bridge with Field Tagging

This block takes a parallel video input and turns it into a stream of valid/ready beats. The input is made of pixel data, an active-video qualifier, a vertical blanking flag and a field-identifier bit. Only active cycles produce beats. The first active pixel after vertical blanking carries a start-of-frame tag on `m_tuser`. The last active pixel of each line carries `m_tlast`. Interlaced standard-definition sources, where alternate fields carry different field-ID values, pass through with their field identity intact. Progressive sources, whose field bit never changes, also pass through.

The field bit is sampled at the first active pixel of each field. It is stored in the buffer next to that pixel. It then appears on `m_field` in the same cycle that the start-of-frame beat is presented. It stays frozen until the next start-of-frame beat. A consumer can therefore sample `m_field` together with the first pixel of a field, and a stream-to-video sink can take it directly.

A small synchronous FIFO in the single clock domain absorbs back-pressure from `m_tready`. If a pixel arrives while the FIFO is full and not draining, that pixel is dropped. A sticky overflow flag is then raised and stays set until reset.

Top module: `vid_stream_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is cleared. In the cycle after, `m_tvalid` is 0, `ovf` is 0 and `m_field` is 0. After reset, the next active pixel is treated as a start of frame.
- R2: Each clock cycle with `vid_active` high produces exactly one beat. The beat carries that cycle's `vid_data`, and beats leave in input order. Cycles with `vid_active` low produce no beat.
- R3: `m_tuser` is 1 on a beat exactly when its pixel is the first active pixel after at least one cycle with `vid_vblank` high, or the first active pixel after reset. Otherwise it is 0.
- R4: `m_tlast` is 1 on a beat exactly when `vid_active` is low in the cycle after its pixel. A line of one pixel gets both `m_tuser` and `m_tlast` if it starts a frame.
- R5: The field bit is taken from `vid_field` at the first active pixel of a field. `m_field` shows that value in every cycle in which that start-of-frame beat is presented. It keeps that value until the next start-of-frame beat is presented. Changes of `vid_field` later in the field have no effect.
- R6: With `vid_field` held constant, `m_field` equals that constant on every beat from the first start-of-frame beat on.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, the presented beat stays unchanged: `m_tvalid`, `m_tdata`, `m_tuser`, `m_tlast` and `m_field` are all held. Up to DEPTH beats are buffered without loss.
- R8: A pixel is dropped when it reaches the buffer while the buffer holds DEPTH beats and no beat leaves in that cycle. `ovf` then goes to 1 and stays 1 until reset, and the beats already stored still come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the video input and the stream output |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_data | input | DW | Pixel value |
| vid_active | input | 1 | High on active pixel cycles |
| vid_vblank | input | 1 | High during vertical blanking |
| vid_field | input | 1 | Field identifier from the source |
| m_tdata | output | DW | Beat pixel data |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Start-of-frame tag |
| m_tlast | output | 1 | End-of-line tag |
| m_field | output | 1 | Field ID, aligned to the stream |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a start-of-frame beat that waits at the head of the buffer under stall. While it waits, the previous field's beats are still draining, and `vid_field` is already toggling. The bench holds `m_tready` low or drives it from a pseudo-random pattern while fields of opposite parity are sent back to back. It compares `m_field` on every accepted beat against the field value expected from the input sequence. A separate scenario keeps `m_tready` low for a line longer than the buffer, which forces a drop. It then checks that only the first DEPTH beats emerge and that `ovf` remains set after draining.

// File: rtl/vsb_pkg.sv
// Package: vsb_pkg
// Shared sideband type for the video-to-stream bridge.
// Assumes nothing beyond a single clock domain.
package vsb_pkg;

    // Sideband carried through the buffer with every pixel
    typedef struct packed {
        logic sof;   // first pixel of a field
        logic eol;   // last pixel of a line
        logic fld;   // field identifier of this pixel's field
    } beat_tag_t;

    localparam int TAG_W = $bits(beat_tag_t);

endpackage

// File: rtl/vsb_framer.sv
// Module: vsb_framer
// Turns active video cycles into tagged pushes. Each pixel is held one
// cycle in a stage register, so that the fall of the active qualifier
// can mark the pixel as end of line. Start of frame is armed by
// vertical blanking or reset and fires on the next active pixel, which
// also captures the field bit for the field.
// Assumes vid_vblank is only high while vid_active is low.
module vsb_framer
    import vsb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vid_data,
    input  logic          vid_active,
    input  logic          vid_vblank,
    input  logic          vid_field,
    output logic          push,
    output logic [DW-1:0] push_data,
    output beat_tag_t     push_tag
);

    logic          sof_pend;
    logic          fld_lat;
    logic          stg_vld;
    logic [DW-1:0] stg_data;
    logic          stg_sof;
    logic          stg_fld;

    // Control state: start-of-frame arming, field latch, stage valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_pend <= 1'b1;
            fld_lat  <= 1'b0;
            stg_vld  <= 1'b0;
            stg_sof  <= 1'b0;
            stg_fld  <= 1'b0;
        end else begin
            stg_vld <= vid_active;
            if (vid_active) begin
                stg_sof  <= sof_pend;
                stg_fld  <= sof_pend ? vid_field : fld_lat;
                if (sof_pend) begin
                    fld_lat <= vid_field;
                end
                sof_pend <= 1'b0;
            end else if (vid_vblank) begin
                sof_pend <= 1'b1;
            end
        end
    end

    // Pixel data stage, no reset needed
    always_ff @(posedge clk) begin
        if (vid_active) begin
            stg_data <= vid_data;
        end
    end

    // Push the staged pixel; end of line when the qualifier has dropped
    always_comb begin
        push         = stg_vld;
        push_data    = stg_data;
        push_tag.sof = stg_sof;
        push_tag.eol = !vid_active;
        push_tag.fld = stg_fld;
    end

endmodule

// File: rtl/vsb_fifo.sv
// Module: vsb_fifo
// Synchronous first-word-fall-through FIFO. A write into a full FIFO is
// accepted only if a read happens in the same cycle. Otherwise it is
// dropped and reported on drop.
// Assumes DEPTH is a power of two.
module vsb_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         drop
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             do_wr;
    logic             do_rd;

    // Status and accepted operations
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_rd   = rd_en && !empty;
        do_wr   = wr_en && (!full || do_rd);
        drop    = wr_en && full && !do_rd;
        rd_data = mem[rd_ptr];
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

endmodule

// File: rtl/vsb_field_hold.sv
// Module: vsb_field_hold
// Re-times the field bit to the stream. A start-of-frame beat at the
// head shows its own field bit. Otherwise the value of the last
// accepted start-of-frame beat is shown.
// Assumes the head sideband is stable while it is not accepted.
module vsb_field_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_sof,
    input  logic head_fld,
    input  logic accept,
    output logic field_out
);

    logic held;

    // Remember the field of the last accepted start-of-frame beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (accept && head_sof) begin
            held <= head_fld;
        end
    end

    // Present the new field in the cycle its first beat is shown
    always_comb begin
        field_out = (head_valid && head_sof) ? head_fld : held;
    end

endmodule

// File: rtl/vid_stream_bridge.sv
// Module: vid_stream_bridge
// Top of the video-to-stream bridge. Chains framer, buffer and field
// re-timer, and keeps the sticky overflow flag.
// Assumes one clock for video and stream, and DEPTH a power of two.
module vid_stream_bridge
    import vsb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vid_data,
    input  logic          vid_active,
    input  logic          vid_vblank,
    input  logic          vid_field,
    output logic [DW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tuser,
    output logic          m_tlast,
    output logic          m_field,
    output logic          ovf
);

    localparam int FW = DW + TAG_W;

    logic          push;
    logic [DW-1:0] push_data;
    beat_tag_t     push_tag;
    logic [FW-1:0] head;
    beat_tag_t     head_tag;
    logic          empty;
    logic          drop;
    logic          accept;

    vsb_framer #(.DW(DW)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_data   (vid_data),
        .vid_active (vid_active),
        .vid_vblank (vid_vblank),
        .vid_field  (vid_field),
        .push       (push),
        .push_data  (push_data),
        .push_tag   (push_tag)
    );

    vsb_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data ({push_data, push_tag}),
        .rd_en   (accept),
        .rd_data (head),
        .empty   (empty),
        .drop    (drop)
    );

    // Unpack the head entry and form the handshake
    always_comb begin
        head_tag = head[TAG_W-1:0];
        m_tdata  = head[FW-1:TAG_W];
        m_tvalid = !empty;
        m_tuser  = head_tag.sof;
        m_tlast  = head_tag.eol;
        accept   = m_tvalid && m_tready;
    end

    vsb_field_hold u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (m_tvalid),
        .head_sof   (head_tag.sof),
        .head_fld   (head_tag.fld),
        .accept     (accept),
        .field_out  (m_field)
    );

    // Sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/vsb_checker.sv
// Module: vsb_checker
// Property checks for vid_stream_bridge, attached by bind.
// Assumes reset is driven low from time zero.
module vsb_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] m_tdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tuser,
    input logic          m_tlast,
    input logic          m_field,
    input logic          ovf
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!m_tvalid && !ovf && !m_field));

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_field != $past(m_field)) |-> (m_tvalid && m_tuser));

    // R7
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
            $stable(m_tuser) && $stable(m_tlast) && $stable(m_field)));

    // R8
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

bind vid_stream_bridge vsb_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast),
    .m_field  (m_field),
    .ovf      (ovf)
);

// File: tb/vid_stream_bridge_tb.sv
// Directed bench for vid_stream_bridge: one task per scenario.
module vid_stream_bridge_tb;

    localparam int DW    = 8;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] vid_data = '0;
    logic          vid_active = 1'b0;
    logic          vid_vblank = 1'b0;
    logic          vid_field = 1'b0;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic          m_tuser;
    logic          m_tlast;
    logic          m_field;
    logic          ovf;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  rdy_mode = 0;     // 0 always ready, 1 pseudo-random, 2 never
    int  exp_cap = -1;     // max expected pushes for current field, -1 none
    logic [DW-1:0] seq = '0;
    logic          cur_field = 1'b0;
    logic [DW+2:0] exp_q [$];  // {data, sof, last, fld}
    logic [15:0]   lfsr = 16'hACE1;

    vid_stream_bridge #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_data   (vid_data),
        .vid_active (vid_active),
        .vid_vblank (vid_vblank),
        .vid_field  (vid_field),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tuser    (m_tuser),
        .m_tlast    (m_tlast),
        .m_field    (m_field),
        .ovf        (ovf)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Ready generator
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m_tready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
        end
    end

    // Monitor: scoreboard plus stall stability, sampled 1 ns after negedge
    initial begin
        logic          pstall;
        logic [DW+3:0] pbeat;
        logic [DW+2:0] e;
        pstall = 0;
        pbeat = '0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                pstall = 0;
            end else begin
                if (pstall) begin
                    chk(m_tvalid && {m_tdata, m_tuser, m_tlast, m_field} == pbeat,
                        "R7", "stalled beat changed",
                        int'({m_tdata, m_tuser, m_tlast, m_field}), int'(pbeat));
                end
                if (m_tvalid && m_tready) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2", "unexpected beat data", int'(m_tdata), -1);
                    end else begin
                        e = exp_q.pop_front();
                        chk(m_tdata == e[DW+2:3], "R2", "beat data",
                            int'(m_tdata), int'(e[DW+2:3]));
                        chk(m_tuser == e[2], "R3", "tuser", int'(m_tuser), int'(e[2]));
                        chk(m_tlast == e[1], "R4", "tlast", int'(m_tlast), int'(e[1]));
                        if (e[2]) begin
                            chk(m_field == e[0], "R5", "field on sof beat",
                                int'(m_field), int'(e[0]));
                            cur_field = e[0];
                        end else begin
                            chk(m_field == cur_field, "R5", "field held in field",
                                int'(m_field), int'(cur_field));
                        end
                    end
                end
                pstall = m_tvalid && !m_tready;
                pbeat  = {m_tdata, m_tuser, m_tlast, m_field};
            end
        end
    end

    task automatic blank(input int n, input logic vb);
        repeat (n) begin
            @(negedge clk);
            vid_active = 1'b0;
            vid_vblank = vb;
        end
    endtask

    // Send one field: vertical blanking, then lines separated by gaps
    task automatic send_field(input logic fld, input int lines, input int ppl,
                              input bit toggle_mid);
        int pushed;
        pushed = 0;
        blank(3, 1'b1);
        blank(1, 1'b0);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < ppl; p++) begin
                @(negedge clk);
                vid_active = 1'b1;
                vid_vblank = 1'b0;
                vid_data   = seq;
                vid_field  = (toggle_mid && l > 0) ? ~fld : fld;
                if (exp_cap < 0 || pushed < exp_cap) begin
                    exp_q.push_back({seq, (l == 0 && p == 0), (p == ppl - 1), fld});
                    pushed++;
                end
                seq = seq + 1'b1;
            end
            blank(2, 1'b0);
        end
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((exp_q.size() != 0 || m_tvalid) && t < 1000) begin
            @(negedge clk);
            t++;
        end
        #1;
        chk(exp_q.size() == 0, "R2", "beats missing after drain", exp_q.size(), 0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        vid_active = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.delete();
        cur_field = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset();
        #1;
        chk(m_tvalid == 1'b0, "R1", "tvalid after reset", int'(m_tvalid), 0);
        chk(ovf == 1'b0, "R1", "ovf after reset", int'(ovf), 0);
        chk(m_field == 1'b0, "R1", "field after reset", int'(m_field), 0);
    endtask

    // Alternating fields; mid-field toggles of the field bit are ignored (R5)
    task automatic t_interlaced;
        rdy_mode = 0;
        send_field(1'b1, 3, 5, 1);
        send_field(1'b0, 3, 5, 1);
        send_field(1'b1, 2, 4, 0);
        drain();
        chk(m_field == 1'b1, "R5", "field after last field", int'(m_field), 1);
    endtask

    // Constant field bit (R6)
    task automatic t_progressive;
        rdy_mode = 0;
        send_field(1'b0, 2, 4, 0);
        drain();
        chk(m_field == 1'b0, "R6", "progressive field frame 1", int'(m_field), 0);
        send_field(1'b0, 2, 4, 0);
        drain();
        chk(m_field == 1'b0, "R6", "progressive field frame 2", int'(m_field), 0);
    endtask

    // Random back-pressure, plus one-pixel lines (R7, R4)
    task automatic t_stall;
        rdy_mode = 1;
        send_field(1'b1, 3, 6, 0);
        send_field(1'b0, 3, 1, 0);
        send_field(1'b1, 2, 3, 1);
        drain();
        rdy_mode = 0;
        chk(m_field == 1'b1, "R7", "field after stalled fields", int'(m_field), 1);
    endtask

    // Overflow: a 20-pixel line into a stalled buffer (R8)
    task automatic t_overflow;
        rdy_mode = 2;
        exp_cap = DEPTH;
        repeat (2) @(negedge clk);
        #1;
        chk(ovf == 1'b0, "R8", "ovf before filling", int'(ovf), 0);
        send_field(1'b0, 1, 20, 0);
        exp_cap = -1;
        repeat (2) @(negedge clk);
        #1;
        chk(ovf == 1'b1, "R8", "ovf after drop", int'(ovf), 1);
        rdy_mode = 0;
        drain();
        chk(ovf == 1'b1, "R8", "ovf sticky after drain", int'(ovf), 1);
        send_field(1'b1, 1, 4, 0);
        drain();
        chk(ovf == 1'b1, "R8", "ovf sticky after traffic", int'(ovf), 1);
        do_reset();
        #1;
        chk(ovf == 1'b0, "R1", "ovf cleared by reset", int'(ovf), 0);
    endtask

    initial begin
        t_reset();
        t_interlaced();
        t_progressive();
        t_stall();
        t_overflow();
        send_field(1'b1, 1, 3, 0);   // first frame after reset (R3)
        drain();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule